// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps a two-bit state, pending and active, for each of a parameterised number of peripheral interrupt lines. Each line is set to level or pulse mode by a mode input. Hardware input activity and software set-pending and clear-pending strobes change the pending bit. A handler-entry acknowledge and a handler-exit strobe, each carrying a line index, move lines into and out of the active state.

From the registered state the block presents one request: the lowest-numbered line that is pending and not active. A core-side sequencer takes that index, acknowledges it on handler entry and signals exit for the same index when the handler returns. Priority levels and preemption are left to the surrounding logic.

When several events reach one line in the same cycle, the next state is formed in this order: the handler exit (if the line is active), then the acknowledge (if the line was pending), then the software clear, then the hardware and software sets. A set therefore always beats a clear.

Top module: `irq_state_tracker`

## Requirements
- R1: A level-mode line (mode bit 0) whose input is high and which is not active after this cycle's exit and acknowledge becomes pending on the next clock.
- R2: A pulse-mode line (mode bit 1) becomes pending on the clock after its input rises. A high that lasts one cycle is enough. The input history resets to 0.
- R3: A software set-pending strobe makes its line pending on the next clock, whatever the mode and the input level.
- R4: An acknowledge for a pending line sets its active bit and clears its pending bit. An acknowledge for a line that is not pending has no effect.
- R5: A handler exit for an active level-mode line clears its active bit and loads its pending bit from the input in that cycle.
- R6: A rising edge on an active pulse-mode line leaves it both active and pending. A later handler exit leaves it pending only.
- R7: A handler exit for an active pulse-mode line with no pending edge returns it to inactive. A handler exit for a line that is not active has no effect.
- R8: A clear-pending strobe on a level-mode line leaves its state unchanged while the input is high. Otherwise it clears the pending bit.
- R9: A clear-pending strobe on a pulse-mode line clears the pending bit and leaves the active bit as it is.
- R10: When a hardware or software set and a clear-pending strobe reach the same line in the same cycle, the line ends pending.
- R11: req_valid_o is high when some line is pending and not active. req_idx_o then gives the lowest such index. With no such line, both outputs are 0. Both outputs follow the registered state combinationally.
- R12: While rst_ni is low, every pending and active bit and req_valid_o read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | Interrupt inputs from peripherals |
| pulse_mode_i | input | NUM_LINES | Per-line mode: 1 selects pulse, 0 selects level |
| sw_set_i | input | NUM_LINES | Software set-pending strobes |
| sw_clr_i | input | NUM_LINES | Software clear-pending strobes |
| ack_valid_i | input | 1 | Handler-entry acknowledge strobe |
| ack_idx_i | input | IDX_W | Line index being acknowledged |
| exit_valid_i | input | 1 | Handler-exit strobe |
| exit_idx_i | input | IDX_W | Line index whose handler returns |
| pending_o | output | NUM_LINES | Registered pending bits |
| active_o | output | NUM_LINES | Registered active bits |
| req_valid_o | output | 1 | Some line is pending and not active |
| req_idx_o | output | IDX_W | Lowest pending, non-active line |

## Verification
A wrong next-state term for a line shows up on pending_o or active_o one clock after the event that exercised it, and req_idx_o can change in that same cycle. A corrupted input history shows up differently: it misses or duplicates a pulse-mode capture, and that difference is visible only on the clock after an input transition. An error in the lowest-index search is visible at once on the request outputs, with no change to any state bit. For these reasons the reference model is compared against every output on every clock, and the request outputs are compared separately from the state bits.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_PULSE = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] hist_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[g] <= 1'b0;
      else         hist_q[g] <= irq_i[g];
    end
    assign rise_o[g] = irq_i[g] & ~hist_q[g];
  end
endmodule

// File: rtl/irq_line_state.sv
module irq_line_state
  import irq_trk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       rise_i,
  input  trig_mode_e mode_i,
  input  logic       sw_set_i,
  input  logic       sw_clr_i,
  input  logic       ack_i,
  input  logic       exit_i,
  output logic       pending_o,
  output logic       active_o
);
  logic pend_q, act_q;
  logic pend_d, act_d;
  logic ack_hit, exit_hit, hw_set;

  assign ack_hit  = ack_i & pend_q;
  assign exit_hit = exit_i & act_q;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (exit_hit) begin
      act_d = 1'b0;
      // level lines are re-sampled on return
      if (mode_i == TRIG_LEVEL) pend_d = irq_i;
    end
    if (ack_hit) begin
      act_d  = 1'b1;
      pend_d = 1'b0;
    end
    if (sw_clr_i && (mode_i == TRIG_PULSE || !irq_i)) pend_d = 1'b0;
    hw_set = (mode_i == TRIG_PULSE) ? rise_i : (irq_i & ~act_d);
    if (hw_set || sw_set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pending_o = pend_q;
  assign active_o  = act_q;

  p_sw_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_set_i |=> pend_q);

  p_pulse_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_PULSE && rise_i) |=> pend_q);

  p_ack_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_q) |=> act_q);

  p_ack_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !pend_q && !act_q && !exit_i) |=> !act_q);

  p_level_exit_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_LEVEL && exit_i && act_q && !irq_i && !sw_set_i && !ack_i)
      |=> (!pend_q && !act_q));

  p_pulse_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_PULSE && sw_clr_i && !rise_i && !sw_set_i && !ack_i && !exit_i)
      |=> (!pend_q && act_q == $past(act_q)));

  p_level_clr_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_LEVEL && sw_clr_i && irq_i && pend_q && !ack_i && !exit_i)
      |=> pend_q);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pending_i,
  input  logic [NUM_LINES-1:0] active_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [NUM_LINES-1:0] cand;
  assign cand = pending_i & ~active_i;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  p_req_is_cand_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pending_i[idx_o] && !active_i[idx_o]));

  p_req_none_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (cand == '0 && idx_o == '0));

  p_req_lowest_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((cand & ((NUM_LINES'(1) << idx_o) - NUM_LINES'(1))) == '0));
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irq_trk_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] pulse_mode_i,
  input  logic [NUM_LINES-1:0] sw_set_i,
  input  logic [NUM_LINES-1:0] sw_clr_i,
  input  logic                 ack_valid_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  input  logic                 exit_valid_i,
  input  logic [IDX_W-1:0]     exit_idx_i,
  output logic [NUM_LINES-1:0] pending_o,
  output logic [NUM_LINES-1:0] active_o,
  output logic                 req_valid_o,
  output logic [IDX_W-1:0]     req_idx_o
);
  logic [NUM_LINES-1:0] rise;

  irq_edge_detect #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .rise_o (rise)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic ack_sel, exit_sel;
    assign ack_sel  = ack_valid_i  && (ack_idx_i  == IDX_W'(g));
    assign exit_sel = exit_valid_i && (exit_idx_i == IDX_W'(g));

    irq_line_state u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .irq_i     (irq_i[g]),
      .rise_i    (rise[g]),
      .mode_i    (trig_mode_e'(pulse_mode_i[g])),
      .sw_set_i  (sw_set_i[g]),
      .sw_clr_i  (sw_clr_i[g]),
      .ack_i     (ack_sel),
      .exit_i    (exit_sel),
      .pending_o (pending_o[g]),
      .active_o  (active_o[g])
    );
  end

  irq_lowest_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pending_o),
    .active_i  (active_o),
    .valid_o   (req_valid_o),
    .idx_o     (req_idx_o)
  );

  p_set_beats_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_set_i & sw_clr_i) != '0) |=> ((pending_o & $past(sw_set_i & sw_clr_i)) == $past(sw_set_i & sw_clr_i)));
endmodule

// File: tb/irq_state_tracker_bench.sv
module irq_state_tracker_bench;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq = '0, mode = '0, sset = '0, sclr = '0;
  logic ack_v = 1'b0, ex_v = 1'b0;
  logic [W-1:0] ack_idx = '0, ex_idx = '0;
  logic [N-1:0] pend_o, act_o;
  logic req_v;
  logic [W-1:0] req_i;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_p[N], m_a[N], m_h[N];

  always #10 clk = ~clk;

  irq_state_tracker #(.NUM_LINES(N)) u_irq_state_tracker (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .pulse_mode_i(mode),
    .sw_set_i(sset), .sw_clr_i(sclr), .ack_valid_i(ack_v), .ack_idx_i(ack_idx),
    .exit_valid_i(ex_v), .exit_idx_i(ex_idx), .pending_o(pend_o), .active_o(act_o),
    .req_valid_o(req_v), .req_idx_o(req_i)
  );

  task automatic model_step();
    for (int i = 0; i < N; i++) begin
      bit p = m_p[i];
      bit a = m_a[i];
      bit rise = irq[i] && !m_h[i];
      bit hw;
      if (ex_v && int'(ex_idx) == i && m_a[i]) begin
        a = 0;
        if (!mode[i]) p = irq[i];
      end
      if (ack_v && int'(ack_idx) == i && m_p[i]) begin
        a = 1;
        p = 0;
      end
      if (sclr[i] && (mode[i] || !irq[i])) p = 0;
      hw = mode[i] ? rise : (irq[i] && !a);
      if (hw || sset[i]) p = 1;
      m_p[i] = p;
      m_a[i] = a;
      m_h[i] = irq[i];
    end
  endtask

  task automatic check_vec(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [N-1:0] ep, ea;
    bit ev = 0;
    int ei = 0;
    for (int i = 0; i < N; i++) begin
      ep[i] = m_p[i];
      ea[i] = m_a[i];
    end
    for (int i = N - 1; i >= 0; i--)
      if (m_p[i] && !m_a[i]) begin ev = 1; ei = i; end
    check_vec(tag, "pending", 32'(pend_o), 32'(ep));
    check_vec(tag, "active", 32'(act_o), 32'(ea));
    check_vec("R11", {tag, " req_valid"}, 32'(req_v), 32'(ev));
    check_vec("R11", {tag, " req_idx"}, 32'(req_i), 32'(ei));
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    #2;
    compare(tag);
    sset = '0; sclr = '0; ack_v = 1'b0; ex_v = 1'b0;
  endtask

  task automatic do_ack(int i);  ack_v = 1'b1; ack_idx = W'(i); endtask
  task automatic do_exit(int i); ex_v = 1'b1;  ex_idx = W'(i);  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_p[i] = 0; m_a[i] = 0; m_h[i] = 0; end
    mode = 8'b0110_0000;  // lines 5,6 pulse
    repeat (3) @(posedge clk);
    #2;
    compare("R12");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: level line 2 high
    irq[2] = 1'b1;
    tick("R1");
    tick("R1");
    // R4: acknowledge, input still high, no re-pend while active
    do_ack(2);
    tick("R4");
    tick("R1");
    // R4: ack of non-pending line 4 ignored
    do_ack(4);
    tick("R4");
    // R5: exit with input high re-pends
    do_exit(2);
    tick("R5");
    do_ack(2);
    tick("R4");
    irq[2] = 1'b0;
    do_exit(2);
    tick("R5");
    // R2: one-cycle pulse on line 5
    irq[5] = 1'b1;
    tick("R2");
    irq[5] = 1'b0;
    tick("R2");
    // R11: lower level line 3 takes the request
    irq[3] = 1'b1;
    tick("R11");
    irq[3] = 1'b0;
    sclr[3] = 1'b1;
    tick("R8");
    // R6: ack pulse line, pulse again while active, then exit
    do_ack(5);
    tick("R4");
    irq[5] = 1'b1;
    tick("R6");
    irq[5] = 1'b0;
    tick("R6");
    do_exit(5);
    tick("R6");
    // R7: ack, exit without pulse, then stray exit
    do_ack(5);
    tick("R7");
    do_exit(5);
    tick("R7");
    do_exit(5);
    tick("R7");
    // R3: software set on level line 1 with input low
    sset[1] = 1'b1;
    tick("R3");
    // R8: clear while high has no effect, then clear while low
    irq[1] = 1'b1;
    tick("R8");
    sclr[1] = 1'b1;
    tick("R8");
    irq[1] = 1'b0;
    sclr[1] = 1'b1;
    tick("R8");
    // R9: pulse line 6 pending -> clear
    irq[6] = 1'b1;
    tick("R9");
    irq[6] = 1'b0;
    sclr[6] = 1'b1;
    tick("R9");
    // R9: active and pending -> active
    sset[6] = 1'b1;
    tick("R9");
    do_ack(6);
    tick("R9");
    irq[6] = 1'b1;
    tick("R9");
    irq[6] = 1'b0;
    sclr[6] = 1'b1;
    tick("R9");
    do_exit(6);
    tick("R9");
    // R10: edge and clear same cycle; sw set and clear same cycle
    irq[5] = 1'b1;
    sclr[5] = 1'b1;
    sset[0] = 1'b1;
    sclr[0] = 1'b1;
    tick("R10");
    irq[5] = 1'b0;
    tick("R10");
    // mixed traffic
    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 0) mode = N'($urandom);
      irq = N'($urandom);
      sset = ($urandom % 8 == 0) ? N'(1 << ($urandom % N)) : '0;
      sclr = ($urandom % 6 == 0) ? N'(1 << ($urandom % N)) : '0;
      if ($urandom % 3 == 0) begin
        ack_v = 1'b1;
        ack_idx = ($urandom % 2 == 0) ? req_i : W'($urandom);
      end
      if ($urandom % 3 == 0) begin
        ex_v = 1'b1;
        ex_idx = W'($urandom);
      end
      tick("R10");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule